// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles the single parity bit of a 32-bit multiplexed address/data bus with a 4-bit command/byte-enable lane, for one agent on that bus. On every clock it registers even parity over the 36 bus bits. When this agent owns the bus value of the previous cycle, it presents that parity on the parity line one clock later.

It also checks parity on the values the agent receives. It compares the registered parity of a received value with the parity bit sampled one clock later. A data mismatch is reported on the data error line. An address mismatch is reported on the open-drain system error line.

The block follows the bus phase on its own. An address phase starts when the frame strobe is asserted on an idle bus. The direction is taken from the command lane in that cycle. From the phase and direction, together with the master/target role flags, the block decides who drives parity and which values it must check. All bus strobes are active-low at the ports. Pad drive enables are separate outputs.

Top module: `pci_parity_unit`

## Requirements
- R1: Whenever `par_oe` is high, the number of ones across the previous cycle's `ad`, `cbe` and the current `par_out` is even.
- R2: `par_out` during a driven cycle is the parity of the bus value from exactly one clock earlier, not of the current value.
- R3: An address phase is a cycle with `frame_n` low in which `frame_n` and `irdy_n` were both high on the previous clock. `cbe[0]` in that cycle selects the direction (1 = write, 0 = read) for the whole transaction. A data cycle is any later cycle with `frame_n` or `irdy_n` low. `par_oe` is high on the clock after an address phase with `is_master` set, after a write data cycle with `is_master` set, and after a read data cycle with `is_target` set. It is low on every other clock.
- R4: A completed data phase is a data cycle with `irdy_n` and `trdy_n` both low. When the agent receives data in it (target on a write, master on a read), `par_in` is sampled on the next clock. If it mismatches, and `perr_en` is high on that clock, `perr_oe` is high and `perr_n` is low for one clock, two clocks after the data phase.
- R5: After an address phase in which `is_master` is low, a mismatching `par_in` on the next clock with `serr_en` high drives `serr_oe` high for exactly one clock, two clocks after the address phase. `serr_n` is always 0, so the line is only ever pulled low.
- R6: With `perr_en` low, `perr_oe` stays low. With `serr_en` low, `serr_oe` stays low. This holds even when parity mismatches.
- R7: A synchronous active-high `rst` clears all parity state. On the clock after it, `par_oe`, `perr_oe` and `serr_oe` are all low, and `perr_n` is high.
- R8: `perr_oe` and `serr_oe` are never high on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad | input | 32 | Address/data bus as seen at the pads |
| cbe | input | 4 | Command/byte-enable lane; bit 0 gives direction in the address phase |
| frame_n | input | 1 | Transaction frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| is_master | input | 1 | This agent is the initiator of the current transaction |
| is_target | input | 1 | This agent is the selected target of the current transaction |
| par_in | input | 1 | Parity bit as seen at the pad |
| perr_en | input | 1 | Allow data parity error reporting |
| serr_en | input | 1 | Allow address parity error reporting |
| par_out | output | 1 | Parity value to drive |
| par_oe | output | 1 | Drive enable for the parity pad |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Drive enable for the data error pad |
| serr_n | output | 1 | System error value, constant low (open drain) |
| serr_oe | output | 1 | Pull-down enable for the system error pad |

## Verification
The bench sweeps a single one across all 36 bus bits, then runs many transactions that vary role, direction, length, wait states and injected parity faults. A design that drove parity in the same cycle as its data, or two cycles late, would fail the one-clock-delay comparison. One that ignored direction would drive parity in read data phases as a master, and a bench target would then see contention. Back-to-back completed phases with faulty parity show whether each error pulse lands exactly two clocks after its own phase. Disabled-reporting cases and a reset in the middle of a burst catch a checker that ignores its enables or leaves a pad enabled.

// File: rtl/pci_parity_unit.sv
module pci_parity_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        trdy_n,
  input  logic        is_master,
  input  logic        is_target,
  input  logic        par_in,
  input  logic        perr_en,
  input  logic        serr_en,
  output logic        par_out,
  output logic        par_oe,
  output logic        perr_n,
  output logic        perr_oe,
  output logic        serr_n,
  output logic        serr_oe
);

  logic frame, irdy, trdy;
  logic busy_q, wr_q, par_q, oe_q, chk_d_q, chk_a_q, perr_q, serr_q;
  logic addr_ph, data_ph, wr_now, rx_data, drive, xfer, mism;

  assign frame   = ~frame_n;
  assign irdy    = ~irdy_n;
  assign trdy    = ~trdy_n;

  assign addr_ph = frame & ~busy_q;
  assign data_ph = busy_q & (frame | irdy);
  assign wr_now  = addr_ph ? cbe[0] : wr_q;
  assign rx_data = wr_now ? is_target : is_master;
  assign drive   = (addr_ph & is_master) | (data_ph & (wr_now ? is_master : is_target));
  assign xfer    = data_ph & irdy & trdy;
  assign mism    = par_q ^ par_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      par_q   <= 1'b0;
      oe_q    <= 1'b0;
      chk_d_q <= 1'b0;
      chk_a_q <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
    end else begin
      busy_q  <= frame | irdy;
      if (addr_ph) wr_q <= cbe[0];
      par_q   <= ^{ad, cbe};
      oe_q    <= drive;
      chk_d_q <= xfer & rx_data;
      chk_a_q <= addr_ph & ~is_master;
      perr_q  <= chk_d_q & mism & perr_en;
      serr_q  <= chk_a_q & mism & serr_en;
    end
  end

  assign par_out = par_q;
  assign par_oe  = oe_q;
  assign perr_oe = perr_q;
  assign perr_n  = ~perr_q;
  assign serr_oe = serr_q;
  assign serr_n  = 1'b0;

  // R7
  a_r7_reset_releases: assert property (@(posedge clk)
    rst |=> (!par_oe && !perr_oe && !serr_oe && perr_n));

  // R6
  a_r6_perr_needs_enable: assert property (@(posedge clk) disable iff (rst)
    perr_oe |-> $past(perr_en));
  a_r6_serr_needs_enable: assert property (@(posedge clk) disable iff (rst)
    serr_oe |-> $past(serr_en));

  // R5
  a_r5_serr_single_clock: assert property (@(posedge clk) disable iff (rst)
    serr_oe |=> !serr_oe);

  // R3
  a_r3_drive_needs_role: assert property (@(posedge clk) disable iff (rst)
    par_oe |-> $past(is_master || is_target));

  // R8
  a_r8_errors_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(perr_oe && serr_oe));

  // R4
  a_r4_perr_after_handshake: assert property (@(posedge clk) disable iff (rst)
    perr_oe |-> $past(!irdy_n && !trdy_n, 2));

endmodule

// File: tb/sim_pci_parity_unit.sv
`timescale 1ns/1ps
module sim_pci_parity_unit;
  logic clk = 1'b0;
  logic rst;
  logic [31:0] ad;
  logic [3:0] cbe;
  logic frame_n, irdy_n, trdy_n, is_master, is_target, par_in, perr_en, serr_en;
  logic par_out, par_oe, perr_n, perr_oe, serr_n, serr_oe;

  always #10 clk = ~clk;

  pci_parity_unit u0 (
    .clk(clk), .rst(rst), .ad(ad), .cbe(cbe), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .is_master(is_master), .is_target(is_target), .par_in(par_in),
    .perr_en(perr_en), .serr_en(serr_en), .par_out(par_out), .par_oe(par_oe),
    .perr_n(perr_n), .perr_oe(perr_oe), .serr_n(serr_n), .serr_oe(serr_oe));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic b_busy = 0, b_wr = 0, pend_d = 0, pend_a = 0, pend_par = 0, next_flip = 0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic step(input logic [31:0] a, input logic [3:0] c, input logic f, ir, tr,
                      input logic m, t, flip);
    logic ba, bd, wr, e_oe, e_par, e_perr, e_serr, p;
    @(negedge clk);
    p = pend_par ^ flip;
    ad = a; cbe = c; frame_n = ~f; irdy_n = ~ir; trdy_n = ~tr;
    is_master = m; is_target = t; par_in = p;
    ba = f & !b_busy;
    bd = b_busy & (f | ir);
    wr = ba ? c[0] : b_wr;
    e_oe = (ba & m) | (bd & (wr ? m : t));
    e_par = ^{a, c};
    e_perr = pend_d & (pend_par ^ p) & perr_en;
    e_serr = pend_a & (pend_par ^ p) & serr_en;
    pend_d = bd & ir & tr & (wr ? t : m);
    pend_a = ba & !m;
    pend_par = e_par;
    b_busy = f | ir;
    if (ba) b_wr = c[0];
    @(posedge clk);
    #5;
    chk(par_oe, e_oe, "R3 par_oe");
    if (e_oe) begin
      chk(par_out, e_par, "R2 par_out delay");
      chk(^{a, c, par_out}, 1'b0, "R1 even parity");
    end
    chk(perr_oe, e_perr, "R4/R6 perr_oe");
    chk(perr_n, !e_perr, "R4 perr_n");
    chk(serr_oe, e_serr, "R5/R6 serr_oe");
    chk(serr_n, 1'b0, "R5 serr_n low");
    chk(perr_oe & serr_oe, 1'b0, "R8 exclusive");
  endtask

  task automatic txn(input logic m, t, wr, input int n, input logic bad_a, bad_d);
    lfsr = nxt(lfsr);
    step(lfsr, {lfsr[7:5], wr}, 1, 0, 0, m, t, next_flip);
    next_flip = bad_a;
    for (int i = 0; i < n; i++) begin
      lfsr = nxt(lfsr);
      if (lfsr[3]) begin
        step(lfsr, lfsr[11:8], 1, 1, 0, m, t, next_flip);
        next_flip = 0;
        lfsr = nxt(lfsr);
      end
      step(lfsr, lfsr[11:8], (i < n - 1), 1, 1, m, t, next_flip);
      next_flip = bad_d;
    end
    step(32'h0, 4'h0, 0, 0, 0, m, t, next_flip);
    next_flip = 0;
    step(32'h0, 4'h0, 0, 0, 0, m, t, 0);
  endtask

  initial begin
    rst = 1; ad = 0; cbe = 0; frame_n = 1; irdy_n = 1; trdy_n = 1;
    is_master = 0; is_target = 0; par_in = 0; perr_en = 1; serr_en = 1;
    @(posedge clk); @(posedge clk); #5;
    chk(par_oe, 1'b0, "R7 reset par_oe");
    chk(perr_oe, 1'b0, "R7 reset perr_oe");
    chk(serr_oe, 1'b0, "R7 reset serr_oe");
    chk(perr_n, 1'b1, "R7 reset perr_n");
    @(negedge clk); rst = 0;

    for (int b = 0; b < 36; b++) begin
      logic [35:0] w;
      w = 36'd1 << b;
      step(w[35:4], {w[3:1], 1'b1}, 1, 0, 0, 1, 0, 0);
      step(~w[35:4], ~w[3:0], 0, 1, 1, 1, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0);
    end

    for (int k = 0; k < 240; k++) begin
      int role;
      role = k % 3;
      perr_en = (k % 7) != 3;
      serr_en = (k % 7) != 5;
      txn(role == 0, role == 1, k[2], 1 + k % 4, (k % 5) == 1, (k % 4) == 2);
    end

    perr_en = 1; serr_en = 1;
    step(32'h1234_5678, 4'h7, 1, 0, 0, 1, 0, 0);
    step(32'hCAFE_0001, 4'h0, 1, 1, 1, 1, 0, 0);
    @(negedge clk); rst = 1;
    @(posedge clk); #5;
    chk(par_oe, 1'b0, "R7 midburst par_oe");
    chk(perr_oe, 1'b0, "R7 midburst perr_oe");
    chk(serr_oe, 1'b0, "R7 midburst serr_oe");
    @(negedge clk); rst = 0; frame_n = 1; irdy_n = 1; trdy_n = 1;
    b_busy = 0; b_wr = 0; pend_d = 0; pend_a = 0; pend_par = 0;
    step(0, 0, 0, 0, 0, 0, 1, 0);
    txn(0, 1, 1, 3, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule